// File: doc/BRIEF.md
# Audio FIFO Level Interrupt Controller

This block is the status and interrupt side of an audio port whose transmit and receive paths each have a left and a right FIFO. The FIFO storage and the serial engine live elsewhere. They hand this block their four fill levels, plus a one-cycle pulse whenever the receive side overflows or the transmit side underflows.

The block compares the levels with two programmable thresholds. It keeps raw interrupt status, with the two error events sticky until software clears them. It applies a mask and drives a single interrupt line.

It also holds the port's control word. Software changes that word through a set address and a clear address rather than by read-modify-write. Two of its bits are FIFO reset commands that fire once and do not stay set.

Software reaches the block through a single-cycle write port and a combinational read port. Both use a 3-bit word address.

Top module: `afifo_irq_ctrl`

## Requirements
- R1: Status bit 0 (receive request) is 1 when the left or the right receive level is greater than or equal to the receive threshold. It reflects the levels present at the previous clock edge.
- R2: Status bit 1 (transmit request) is 1 when the left or the right transmit level is less than or equal to the transmit threshold. It reflects the levels present at the previous clock edge.
- R3: Status bit 2 (receive overflow) and bit 3 (transmit underflow) are set by a pulse on `rx_ovf_evt` or `tx_udf_evt` and stay set until cleared. If an event and a clear of the same bit happen in one cycle, the bit is left set.
- R4: Writing to address 5 with a one in bit 2 or bit 3 clears that status bit. Bits 0 and 1 follow the levels and are not affected. Writing 0x0F clears every error bit that has no new event in that cycle.
- R5: The mask register (address 4, bits 3:0, same positions as the status) is read back at address 4. A one in a mask bit keeps that status bit from reaching `irq`.
- R6: `irq` is the OR of the unmasked status bits. Status bit 0 also needs control bit 5, and status bit 1 also needs control bit 4. The raw status at address 3 is shown whatever the mask and enables are.
- R7: The threshold register at address 2 holds the transmit threshold in bits 7:0 and the receive threshold in bits 15:8. Both reset to 8.
- R8: Address 6 returns the transmit levels and address 7 returns the receive levels. Each word has the left level in bits 7:0 and the right level in bits 15:8.
- R9: Control bits are 0 transmit enable (`tx_en`), 1 receive enable (`rx_en`), 4 transmit interrupt enable and 5 receive interrupt enable. A write to address 0 sets the bits written as one. A write to address 1 clears them. Addresses 0 and 1 both read back the control word.
- R10: A write to address 0 with bit 2 (or bit 3) set raises `tx_fifo_rst` (or `rx_fifo_rst`) for exactly the following cycle. These bits always read back as 0. Writing them to address 1 does nothing.
- R11: After reset the control word, mask and status are 0, the threshold register reads 0x0808, and `irq` and both reset pulses are low.
- R12: Address 5 reads as 0. Writes to addresses 3, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| tx_lvl_l | input | 8 | Left transmit FIFO level |
| tx_lvl_r | input | 8 | Right transmit FIFO level |
| rx_lvl_l | input | 8 | Left receive FIFO level |
| rx_lvl_r | input | 8 | Right receive FIFO level |
| rx_ovf_evt | input | 1 | One-cycle receive overflow event |
| tx_udf_evt | input | 1 | One-cycle transmit underflow event |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| tx_fifo_rst | output | 1 | One-cycle transmit FIFO reset |
| rx_fifo_rst | output | 1 | One-cycle receive FIFO reset |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong sticky bit or a lost clear shows at the status word and at `irq` one cycle after the event or the write, and it persists. Nothing later corrects it, so the error stays visible until the next clear.

A wrong comparison sense or an off-by-one boundary shows only when a level sits exactly on its threshold. The stimulus therefore keeps the levels near the thresholds and also moves the thresholds to 0 and 255.

A stuck or repeated FIFO reset pulse, or a control bit that survives its clear, is visible on the output pins one cycle after the write.

// File: rtl/afifo_irq_pkg.sv
package afifo_irq_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned ST_W   = 4;
  localparam int unsigned CTRL_W = 6;

  localparam logic [ADDR_W-1:0] A_CTRL_SET = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL_CLR = 3'd1;
  localparam logic [ADDR_W-1:0] A_THRESH   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RAW      = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK     = 3'd4;
  localparam logic [ADDR_W-1:0] A_ICLR     = 3'd5;
  localparam logic [ADDR_W-1:0] A_TX_LVL   = 3'd6;
  localparam logic [ADDR_W-1:0] A_RX_LVL   = 3'd7;

  // control word bit positions
  localparam int unsigned C_TX_EN  = 0;
  localparam int unsigned C_RX_EN  = 1;
  localparam int unsigned C_TX_RST = 2;
  localparam int unsigned C_RX_RST = 3;
  localparam int unsigned C_TX_IE  = 4;
  localparam int unsigned C_RX_IE  = 5;

  // status bit positions
  localparam int unsigned S_RX_REQ = 0;
  localparam int unsigned S_TX_REQ = 1;
  localparam int unsigned S_RX_OVF = 2;
  localparam int unsigned S_TX_UDF = 3;
endpackage

// File: rtl/afifo_irq_ctrlreg.sv
module afifo_irq_ctrlreg
  import afifo_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              tx_rst_p,
  output logic              rx_rst_p
);
  localparam logic [CTRL_W-1:0] KEEP =
    CTRL_W'((1 << C_TX_EN) | (1 << C_RX_EN) | (1 << C_TX_IE) | (1 << C_RX_IE));

  logic [CTRL_W-1:0] ctrl_d;
  logic              upd_en;
  logic              tx_rst_d, rx_rst_d;

  always_comb begin
    upd_en = set_we | clr_we;
    ctrl_d = ctrl_q;
    if (set_we) ctrl_d = ctrl_d | (wdata & KEEP);
    if (clr_we) ctrl_d = ctrl_d & ~(wdata & KEEP);
    tx_rst_d = set_we & wdata[C_TX_RST];
    rx_rst_d = set_we & wdata[C_RX_RST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (upd_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rst_p <= 1'b0;
      rx_rst_p <= 1'b0;
    end else begin
      tx_rst_p <= tx_rst_d;
      rx_rst_p <= rx_rst_d;
    end
  end

  p_set_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && wdata[C_TX_EN]) |=> ctrl_q[C_TX_EN]);
  p_clr_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wdata[C_RX_EN]) |=> !ctrl_q[C_RX_EN]);
  p_pulse_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_p |-> $past(set_we && wdata[C_TX_RST]));
  p_pulse_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rst_p && !$past(set_we && wdata[C_RX_RST])) |-> 1'b0);
endmodule

// File: rtl/afifo_irq_lvlcmp.sv
module afifo_irq_lvlcmp #(
  parameter int unsigned LVL_W    = 8,
  parameter bit          AT_ABOVE = 1'b1
) (
  input  logic [LVL_W-1:0] lvl_l,
  input  logic [LVL_W-1:0] lvl_r,
  input  logic [LVL_W-1:0] thr,
  output logic             req
);
  logic [1:0] hit;
  generate
    if (AT_ABOVE) begin : g_above
      always_comb begin
        hit[0] = (lvl_l >= thr);
        hit[1] = (lvl_r >= thr);
      end
    end else begin : g_below
      always_comb begin
        hit[0] = (lvl_l <= thr);
        hit[1] = (lvl_r <= thr);
      end
    end
  endgenerate
  assign req = |hit;
endmodule

// File: rtl/afifo_irq_status.sv
module afifo_irq_status
  import afifo_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_req,
  input  logic            tx_req,
  input  logic            ovf_ev,
  input  logic            udf_ev,
  input  logic            clr_we,
  input  logic            mask_we,
  input  logic [ST_W-1:0] wd,
  input  logic            rx_ie,
  input  logic            tx_ie,
  output logic [ST_W-1:0] st_q,
  output logic [ST_W-1:0] mask_q,
  output logic            irq
);
  logic [ST_W-1:0] st_d;
  logic [ST_W-1:0] clr_bits;
  logic [ST_W-1:0] gate;

  always_comb begin
    clr_bits = clr_we ? wd : '0;
    st_d = '0;
    st_d[S_RX_REQ] = rx_req;
    st_d[S_TX_REQ] = tx_req;
    st_d[S_RX_OVF] = (st_q[S_RX_OVF] & ~clr_bits[S_RX_OVF]) | ovf_ev;
    st_d[S_TX_UDF] = (st_q[S_TX_UDF] & ~clr_bits[S_TX_UDF]) | udf_ev;
    gate = '1;
    gate[S_RX_REQ] = rx_ie;
    gate[S_TX_REQ] = tx_ie;
    irq = |(st_q & ~mask_q & gate);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wd;
  end

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[S_RX_OVF] && !(clr_we && wd[S_RX_OVF])) |=> st_q[S_RX_OVF]);
  p_event_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    udf_ev |=> st_q[S_TX_UDF]);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wd[S_TX_UDF] && !udf_ev) |=> !st_q[S_TX_UDF]);
endmodule

// File: rtl/afifo_irq_ctrl.sv
module afifo_irq_ctrl
  import afifo_irq_pkg::*;
#(
  parameter int unsigned LVL_W   = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned THR_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [LVL_W-1:0]  tx_lvl_l,
  input  logic [LVL_W-1:0]  tx_lvl_r,
  input  logic [LVL_W-1:0]  rx_lvl_l,
  input  logic [LVL_W-1:0]  rx_lvl_r,
  input  logic              rx_ovf_evt,
  input  logic              tx_udf_evt,
  output logic              tx_en,
  output logic              rx_en,
  output logic              tx_fifo_rst,
  output logic              rx_fifo_rst,
  output logic              irq
);
  localparam int unsigned PAIR_W = 2 * LVL_W;
  localparam logic [LVL_W-1:0] THR_INIT = LVL_W'(THR_RST);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  // write decode
  logic set_we, clr_we, thr_we, mask_we, iclr_we;
  always_comb begin
    set_we  = wr_en & (wr_addr == A_CTRL_SET);
    clr_we  = wr_en & (wr_addr == A_CTRL_CLR);
    thr_we  = wr_en & (wr_addr == A_THRESH);
    mask_we = wr_en & (wr_addr == A_MASK);
    iclr_we = wr_en & (wr_addr == A_ICLR);
  end

  // thresholds
  logic [LVL_W-1:0] thr_tx_q, thr_rx_q, thr_tx_d, thr_rx_d;
  always_comb begin
    thr_tx_d = wr_data[LVL_W-1:0];
    thr_rx_d = wr_data[PAIR_W-1:LVL_W];
  end
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      thr_tx_q <= THR_INIT;
      thr_rx_q <= THR_INIT;
    end else if (thr_we) begin
      thr_tx_q <= thr_tx_d;
      thr_rx_q <= thr_rx_d;
    end
  end

  // control word
  logic [CTRL_W-1:0] ctrl_q;
  afifo_irq_ctrlreg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .set_we   (set_we),
    .clr_we   (clr_we),
    .wdata    (wr_data[CTRL_W-1:0]),
    .ctrl_q   (ctrl_q),
    .tx_rst_p (tx_fifo_rst),
    .rx_rst_p (rx_fifo_rst)
  );
  assign tx_en = ctrl_q[C_TX_EN];
  assign rx_en = ctrl_q[C_RX_EN];

  // level comparisons
  logic rx_req, tx_req;
  afifo_irq_lvlcmp #(.LVL_W(LVL_W), .AT_ABOVE(1'b1)) u_rx_cmp (
    .lvl_l (rx_lvl_l),
    .lvl_r (rx_lvl_r),
    .thr   (thr_rx_q),
    .req   (rx_req)
  );
  afifo_irq_lvlcmp #(.LVL_W(LVL_W), .AT_ABOVE(1'b0)) u_tx_cmp (
    .lvl_l (tx_lvl_l),
    .lvl_r (tx_lvl_r),
    .thr   (thr_tx_q),
    .req   (tx_req)
  );

  // status, mask, interrupt
  logic [ST_W-1:0] st_q, mask_q;
  afifo_irq_status u_stat (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .rx_req  (rx_req),
    .tx_req  (tx_req),
    .ovf_ev  (rx_ovf_evt),
    .udf_ev  (tx_udf_evt),
    .clr_we  (iclr_we),
    .mask_we (mask_we),
    .wd      (wr_data[ST_W-1:0]),
    .rx_ie   (ctrl_q[C_RX_IE]),
    .tx_ie   (ctrl_q[C_TX_IE]),
    .st_q    (st_q),
    .mask_q  (mask_q),
    .irq     (irq)
  );

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL_SET, A_CTRL_CLR: rd_data[CTRL_W-1:0] = ctrl_q;
      A_THRESH: begin
        rd_data[LVL_W-1:0]      = thr_tx_q;
        rd_data[PAIR_W-1:LVL_W] = thr_rx_q;
      end
      A_RAW:  rd_data[ST_W-1:0] = st_q;
      A_MASK: rd_data[ST_W-1:0] = mask_q;
      A_TX_LVL: begin
        rd_data[LVL_W-1:0]      = tx_lvl_l;
        rd_data[PAIR_W-1:LVL_W] = tx_lvl_r;
      end
      A_RX_LVL: begin
        rd_data[LVL_W-1:0]      = rx_lvl_l;
        rd_data[PAIR_W-1:LVL_W] = rx_lvl_r;
      end
      default: rd_data = '0;
    endcase
  end

  p_mask_all_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (&mask_q) |-> !irq);
  p_ien_gate_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!ctrl_q[C_TX_IE] && !ctrl_q[C_RX_IE] && mask_q[S_RX_OVF] && mask_q[S_TX_UDF]) |-> !irq);
  p_rst_bits_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    !ctrl_q[C_TX_RST] && !ctrl_q[C_RX_RST]);
endmodule

// File: tb/afifo_irq_ctrl_test.sv
module afifo_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic [7:0]  tx_lvl_l, tx_lvl_r, rx_lvl_l, rx_lvl_r;
  logic        rx_ovf_evt, tx_udf_evt;
  logic        tx_en, rx_en, tx_fifo_rst, rx_fifo_rst, irq;

  always #5 clk = ~clk;

  afifo_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_lvl_l(tx_lvl_l), .tx_lvl_r(tx_lvl_r), .rx_lvl_l(rx_lvl_l), .rx_lvl_r(rx_lvl_r),
    .rx_ovf_evt(rx_ovf_evt), .tx_udf_evt(tx_udf_evt),
    .tx_en(tx_en), .rx_en(rx_en), .tx_fifo_rst(tx_fifo_rst), .rx_fifo_rst(rx_fifo_rst),
    .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_ctrl, m_mask, m_st, m_thr_tx, m_thr_rx, m_nst;
  bit m_txp, m_rxp;
  bit [1:0] m_sync;

  task automatic m_clear();
    m_ctrl = 0; m_mask = 0; m_st = 0; m_thr_tx = 8; m_thr_rx = 8;
    m_txp = 0; m_rxp = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_clear();
      m_sync = 2'b00;
    end else begin
      if (!m_sync[1]) m_clear();
      else begin
        m_nst = 0;
        if (int'(rx_lvl_l) >= m_thr_rx || int'(rx_lvl_r) >= m_thr_rx) m_nst += 1;
        if (int'(tx_lvl_l) <= m_thr_tx || int'(tx_lvl_r) <= m_thr_tx) m_nst += 2;
        if (((m_st & 4) != 0 && !(wr_en && wr_addr == 5 && wr_data[2])) || rx_ovf_evt) m_nst += 4;
        if (((m_st & 8) != 0 && !(wr_en && wr_addr == 5 && wr_data[3])) || tx_udf_evt) m_nst += 8;
        m_txp = wr_en && wr_addr == 0 && wr_data[2];
        m_rxp = wr_en && wr_addr == 0 && wr_data[3];
        if (wr_en) begin
          case (wr_addr)
            3'd0: m_ctrl = m_ctrl | (int'(wr_data) & 'h33);
            3'd1: m_ctrl = m_ctrl & ~(int'(wr_data) & 'h33);
            3'd2: begin m_thr_tx = int'(wr_data) % 256; m_thr_rx = int'(wr_data) / 256; end
            3'd4: m_mask = int'(wr_data) & 15;
            default: ;
          endcase
        end
        m_st = m_nst;
      end
      m_sync = {m_sync[0], 1'b1};
    end
  end

  function automatic int exp_irq();
    int r = 0;
    if ((m_st & 1) && !(m_mask & 1) && (m_ctrl & 'h20)) r = 1;
    if ((m_st & 2) && !(m_mask & 2) && (m_ctrl & 'h10)) r = 1;
    if ((m_st & 4) && !(m_mask & 4)) r = 1;
    if ((m_st & 8) && !(m_mask & 8)) r = 1;
    return r;
  endfunction

  function automatic int exp_rd(int a);
    case (a)
      0, 1: return m_ctrl;
      2: return m_thr_rx * 256 + m_thr_tx;
      3: return m_st;
      4: return m_mask;
      6: return int'(tx_lvl_r) * 256 + int'(tx_lvl_l);
      7: return int'(rx_lvl_r) * 256 + int'(rx_lvl_l);
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(int a);
    case (a)
      0, 1: return "R9 ctrl readback";
      2: return "R7 thresholds";
      3: return "R1 R2 R3 R4 R6 raw status";
      4: return "R5 mask";
      5: return "R12 clear address reads zero";
      default: return "R8 levels";
    endcase
  endfunction

  task automatic chk(int act, int exp, string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!m_sync[1]) begin
        chk(int'(irq), 0, "R11 irq after reset");
        chk(int'(tx_fifo_rst) + int'(rx_fifo_rst), 0, "R11 pulses after reset");
        chk(int'(rd_data), exp_rd(int'(rd_addr)), "R11 register reset value");
      end else begin
        chk(int'(irq), exp_irq(), "R5 R6 irq");
        chk(int'(tx_en), m_ctrl & 1, "R9 tx_en");
        chk(int'(rx_en), (m_ctrl >> 1) & 1, "R9 rx_en");
        chk(int'(tx_fifo_rst), int'(m_txp), "R10 tx_fifo_rst");
        chk(int'(rx_fifo_rst), int'(m_rxp), "R10 rx_fifo_rst");
        chk(int'(rd_data), exp_rd(int'(rd_addr)), rd_tag(int'(rd_addr)));
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // advance one cycle; inputs change 1 ns after the edge
  task automatic tick();
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    rx_ovf_evt = 1'b0;
    tx_udf_evt = 1'b0;
    rd_addr = rd_addr + 3'd1;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    tick();
  endtask

  task automatic lv(int tl, int tr, int rl, int rr);
    tx_lvl_l = 8'(tl); tx_lvl_r = 8'(tr); rx_lvl_l = 8'(rl); rx_lvl_r = 8'(rr);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    rx_ovf_evt = 1'b0; tx_udf_evt = 1'b0;
    lv(20, 20, 0, 0);
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(10);                      // R11 reset values through all addresses
    wr(0, 'h33); idle(8);          // R9 set
    wr(1, 'h01); idle(8);          // R9 clear
    wr(0, 'h04); wr(0, 'h08); idle(2);   // R10 pulses
    wr(1, 'h0C); idle(2);          // R10 clear address ignores reset bits
    wr(0, 'h0C); wr(0, 'h0C); idle(3);   // R10 back to back
    wr(2, 'h0503); idle(8);        // R7
    lv(4, 9, 4, 2); idle(8);       // R1 R2 just off boundary
    lv(9, 3, 2, 5); idle(8);       // R1 R2 exactly on boundary
    rx_ovf_evt = 1; tick(); idle(8);           // R3
    wr_en = 1; wr_addr = 5; wr_data = 16'h0F; rx_ovf_evt = 1; tick(); idle(8); // R3 event wins
    wr(5, 'h0F); idle(8);          // R4
    tx_udf_evt = 1; tick(); idle(4);
    wr(4, 'h0F); idle(8);          // R5 all masked
    wr(4, 'h07); idle(8);
    wr(3, 'hFFFF); wr(6, 'hFFFF); wr(7, 'hFFFF); idle(8);  // R12
    wr(5, 'h08); wr(4, 0);
    wr(2, 'h00FF); lv(255, 255, 0, 0); idle(8);  // R1 R2 extremes
    wr(2, 'hFF00); lv(1, 0, 254, 255); idle(8);
    wr(2, 'h0808);
    for (int c = 0; c < 6000; c++) begin
      lv($urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(0, 12));
      rx_ovf_evt = ($urandom_range(0, 15) == 0);
      tx_udf_evt = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 2) == 0) begin
        wr_en = 1'b1;
        wr_addr = 3'($urandom_range(0, 7));
        wr_data = 16'($urandom_range(0, 65535));
        if (wr_addr == 2 && $urandom_range(0, 1) == 0)
          wr_data = 16'($urandom_range(4, 11) * 256 + $urandom_range(0, 8));
      end
      tick();
    end
    idle(4);
    done = 1;
    summary();
    $finish;
  end
endmodule